// File: doc/BRIEF.md
# Upstream Nibble Serializer with Burst-Enable Alignment

This block turns 4-bit parallel words into a single serial stream for the upstream link of a passive optical network terminal. Each word travels together with one burst-enable bit through a four-slot elastic buffer. A serial-rate clock drains the buffer one word per nibble period, shifting the word out most significant bit first. The stored burst-enable bit comes out beside its own word, so the laser-enable output rises on the same serial bit time as that word's first bit.

The serial clock is the loop-timed clock recovered from the downstream signal. The word-rate clock is modelled as a one-cycle strobe, `par_tick`, in the serial clock domain. Both clocks share one source, so their ratio is a fixed 4:1. `par_tick` works as a valid qualifier: a word and its enable bit are taken only on a cycle where it is high. There is no ready signal and no back-pressure, because the serial line cannot stall. Instead, the producer must offer exactly one word per nibble period on average, and a slip in that rate is reported as a buffer error.

A synchronous buffer reset (`fifo_rst`) restores the buffer to holding two zero-valued words. An error, or a reset in progress, silences both the serial data and the burst enable, so the laser never emits a corrupted burst.

Top module: `sbe_serializer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `ser_data`, `ben_out` and `fifo_err` are 0.
- R2: Every fourth clock edge after reset (the edge that ends phase 3 of an internal phase counter, which starts at 0) loads the oldest buffered word. Its bits 3, 2, 1 and 0 then appear on `ser_data`, one per cycle in that order.
- R3: Each word's burst-enable bit is held in the same buffer slot as the word. `ben_out` equals that bit for exactly the four cycles in which the word is on `ser_data`. `ben_out` can therefore change only at a word boundary, or when it is forced low.
- R4: A cycle with `fifo_rst` high clears the error flag and restores two zero words (data 0, enable 0) ahead of the next written word. The reset also restarts the phase. While `fifo_rst` is high, `ser_data` and `ben_out` are 0 in the same cycle.
- R5: A word load that finds the buffer empty (underflow) sets `fifo_err` on that edge.
- R6: A write into a full buffer (4 words) on an edge with no load (overflow) sets `fifo_err` on that edge.
- R7: Once `fifo_err` is set, it stays set until `fifo_rst`. While it is set, writes and loads have no effect.
- R8: While `fifo_err` is 1, `ser_data` and `ben_out` are 0.
- R9: On cycles with `par_tick` low, `par_data` and `par_ben` are ignored and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-rate loop-timed clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_rst | input | 1 | Synchronous buffer reset; silences outputs while high |
| par_tick | input | 1 | Word-rate strobe; qualifies par_data and par_ben |
| par_data | input | 4 | Parallel word, bit 3 sent first |
| par_ben | input | 1 | Burst enable belonging to par_data |
| ser_data | output | 1 | Serial data stream |
| ben_out | output | 1 | Laser burst enable aligned to serial words |
| fifo_err | output | 1 | Sticky overflow/underflow flag |

## Verification
The bench runs bursts where `ben_out` must switch on the first bit of the flagged word. A design that delays the enable by one cycle, or tracks it outside the buffer, shows the enable offset from the word it belongs to. Stopping the word strobe drains the buffer and must raise an underflow. Strobing every cycle must raise an overflow. A design with a non-sticky flag, or one that keeps transmitting while in error, leaks bits onto the line. A reset during an active burst must drop the enable at once and bring back the two-word preload. A wrong preload or a missing phase restart shifts every later word by whole nibbles.

// File: rtl/sbe_pkg.sv
package sbe_pkg;
  parameter int unsigned NIB_W = 4;

  typedef struct packed {
    logic             ben;
    logic [NIB_W-1:0] data;
  } slot_t;
endpackage

// File: rtl/sbe_phase.sv
module sbe_phase
  import sbe_pkg::*;
#(
  parameter int unsigned PW = $clog2(NIB_W)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic last
);
  logic [PW-1:0] ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ph <= '0;
    else if (clr) ph <= '0;
    else          ph <= ph + 1'b1;
  end

  assign last = (ph == PW'(NIB_W - 1));
endmodule

// File: rtl/sbe_fifo.sv
module sbe_fifo
  import sbe_pkg::*;
#(
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned PRELOAD = 2,
  parameter int unsigned AW      = $clog2(DEPTH),
  parameter int unsigned LW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  slot_t         wr_slot,
  input  logic          rd_en,
  output slot_t         rd_slot,
  output logic          err,
  output logic [LW-1:0] level
);
  slot_t         mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          under, over;

  assign under   = rd_en && (level == '0);
  assign over    = wr_en && !rd_en && (level == LW'(DEPTH));
  assign rd_slot = mem[rp];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      wp    <= AW'(PRELOAD);
      rp    <= '0;
      level <= LW'(PRELOAD);
      err   <= 1'b0;
    end else if (clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      wp    <= AW'(PRELOAD);
      rp    <= '0;
      level <= LW'(PRELOAD);
      err   <= 1'b0;
    end else if (!err) begin
      if (under || over) begin
        err <= 1'b1;
      end else begin
        if (rd_en) rp <= bump(rp);
        if (wr_en) begin
          mem[wp] <= wr_slot;
          wp      <= bump(wp);
        end
        level <= level + LW'(wr_en) - LW'(rd_en);
      end
    end
  end
endmodule

// File: rtl/sbe_shift.sv
module sbe_shift
  import sbe_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  load,
  input  slot_t slot_in,
  input  logic  mute,
  output logic  ser_out,
  output logic  ben_out
);
  logic [NIB_W-1:0] sh;
  logic             ben_q;
  logic             vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; ben_q <= 1'b0; vld <= 1'b0;
    end else if (clr) begin
      sh <= '0; ben_q <= 1'b0; vld <= 1'b0;
    end else if (load) begin
      sh <= slot_in.data; ben_q <= slot_in.ben; vld <= 1'b1;
    end else begin
      sh <= {sh[NIB_W-2:0], 1'b0};
    end
  end

  assign ser_out = vld && sh[NIB_W-1] && !mute;
  assign ben_out = vld && ben_q && !mute;
endmodule

// File: rtl/sbe_serializer.sv
module sbe_serializer
  import sbe_pkg::*;
#(
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned PRELOAD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_rst,
  input  logic             par_tick,
  input  logic [NIB_W-1:0] par_data,
  input  logic             par_ben,
  output logic             ser_data,
  output logic             ben_out,
  output logic             fifo_err
);
  localparam int unsigned LW = $clog2(DEPTH + 1);

  logic          nib_last;
  logic [LW-1:0] fifo_level;
  slot_t         in_slot, out_slot;

  assign in_slot = '{ben: par_ben, data: par_data};

  sbe_phase u_phase (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (fifo_rst),
    .last (nib_last)
  );

  sbe_fifo #(.DEPTH(DEPTH), .PRELOAD(PRELOAD)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (fifo_rst),
    .wr_en  (par_tick),
    .wr_slot(in_slot),
    .rd_en  (nib_last),
    .rd_slot(out_slot),
    .err    (fifo_err),
    .level  (fifo_level)
  );

  sbe_shift u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (fifo_rst),
    .load   (nib_last && !fifo_err),
    .slot_in(out_slot),
    .mute   (fifo_err || fifo_rst),
    .ser_out(ser_data),
    .ben_out(ben_out)
  );
endmodule

// File: rtl/sbe_checker.sv
module sbe_checker #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned LW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_rst,
  input logic          par_tick,
  input logic          ser_data,
  input logic          ben_out,
  input logic          fifo_err,
  input logic          nib_last,
  input logic [LW-1:0] fifo_level
);
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_err && !fifo_rst |=> fifo_err); // R7

  AST_RST_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rst |=> !fifo_err); // R4

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_err |-> (!ser_data && !ben_out)); // R8

  AST_BEN_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !nib_last && !par_tick |=> ($stable(ben_out) || fifo_rst)); // R3

  AST_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    nib_last && fifo_level == '0 && !fifo_rst |=> fifo_err); // R5

  AST_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    par_tick && !nib_last && fifo_level == LW'(DEPTH) && !fifo_rst |=> fifo_err); // R6
endmodule

bind sbe_serializer sbe_checker #(.DEPTH(DEPTH), .LW(LW)) u_chk (.*);

// File: tb/sim_sbe_serializer.sv
module sim_sbe_serializer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_rst = 1'b0;
  logic       par_tick = 1'b0;
  logic [3:0] par_data = '0;
  logic       par_ben = 1'b0;
  logic       ser_data, ben_out, fifo_err;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  sbe_serializer u0 (.*);

  always #5 clk = ~clk;

  // Behavioural reference model
  int q[$];
  int ph = 0;
  int cur = 0;
  int idx = 0;
  bit curv = 0;
  bit merr = 0;

  always @(posedge clk) begin
    if (!rst_n || fifo_rst) begin
      q = '{0, 0}; ph = 0; curv = 0; merr = 0; idx = 0;
    end else begin
      bit rd, und, ovr;
      rd  = (ph == 3);
      und = rd && q.size() == 0;
      ovr = par_tick && !rd && q.size() == 4;
      if (!merr) begin
        if (und || ovr) merr = 1;
        else begin
          if (rd) begin cur = q.pop_front(); curv = 1; idx = 3; end
          else idx = idx - 1;
          if (par_tick) q.push_back({27'd0, par_ben, par_data});
        end
      end
      ph = (ph + 1) % 4;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit gate, es, eb;
      gate = merr || fifo_rst || !rst_n;
      es = !gate && curv && idx >= 0 && ((cur >> idx) & 1) == 1;
      eb = !gate && curv && ((cur >> 4) & 1) == 1;
      if (!rst_n) begin
        chk("R1 ser_data in reset", ser_data, 1'b0);
        chk("R1 ben_out in reset", ben_out, 1'b0);
        chk("R1 fifo_err in reset", fifo_err, 1'b0);
      end else begin
        chk("R2/R8 ser_data", ser_data, es);
        chk("R3/R4 ben_out", ben_out, eb);
        chk("R5/R6/R7 fifo_err", fifo_err, merr);
      end
    end
  end

  task automatic cyc(input bit tick, input bit ben, input bit frst);
    @(negedge clk); #1;
    par_tick = tick;
    par_ben  = ben;
    fifo_rst = frst;
    par_data = 4'($urandom); // R9: data keeps moving while par_tick is low
  endtask

  task automatic words(input int n, input int ben_lo, input int ben_hi);
    for (int w = 0; w < n; w++)
      for (int c = 0; c < 4; c++)
        cyc(c == 1, (c == 1) && w >= ben_lo && w <= ben_hi, 1'b0);
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) cyc(0, 0, 0);
    @(negedge clk); #1; rst_n = 1'b1;
    words(30, 5, 12);          // R2 R3: steady stream with one burst
    words(10, 2, 2);           // R3: single-word burst
    words(4, 0, 3);            // R4: reset mid burst
    cyc(0, 0, 1); cyc(0, 0, 1);
    words(12, 3, 7);
    for (int i = 0; i < 16; i++) cyc(0, 0, 0);   // R5: starve reads
    for (int i = 0; i < 8; i++) cyc(1, 1, 0);    // R7: ignored while in error
    cyc(0, 0, 1);
    words(8, 1, 4);
    for (int i = 0; i < 8; i++) cyc(1, 1, 0);    // R6: overrun writes
    for (int i = 0; i < 6; i++) cyc(0, 0, 0);
    cyc(0, 0, 1);
    words(20, 4, 9);
    cyc(0, 0, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule